// File: doc/BRIEF.md
# Bus Mode Qualification Controller

This block decides which kind of driver population is present on a differential bus, and whether the local line termination may be switched on. An analog front end compares the bus-sense level against three windows: below the low threshold, inside the middle window, and above the high threshold. The block receives the three comparator results as digital flags. It synchronises them and classifies each sample as single-ended, low-voltage differential or high-voltage differential. A classification becomes the qualified mode only after it has held without interruption for a long qualification delay. The nominal delay is 190 ms, and the clock frequency and delay are parameters.

Termination is switched on only while the qualified mode is low-voltage differential. A disconnect request or an over-temperature flag also forces termination off. Neither override stops or disturbs mode qualification. All inputs are plain level signals with no handshake, and the outputs are plain levels that are valid on every cycle.

Top module: `busmode_qual`

## Requirements
- R1: While `rst` is high and afterwards until a new mode qualifies, `mode_code` is 2'b00 and both `term_en` and `lvd_stat` are 0. Reset also clears any partly elapsed qualification, so a full delay is needed again after reset.
- R2: `mode_code` encodes single-ended as 2'b00, low-voltage differential as 2'b01 and high-voltage differential as 2'b10, and never shows 2'b11.
- R3: Each synchronised sample is classified with the following priority: `sense_lo` gives single-ended, even when `sense_hi` is also set; otherwise `sense_hi` gives high-voltage differential; otherwise `sense_mid` gives low-voltage differential. A sample with no flag set keeps the previous candidate.
- R4: A candidate that differs from the qualified mode becomes the qualified mode after it has held for QUAL_CYCLES = CLK_KHZ*DELAY_MS cycles. Measured from the input change, the latency is between QUAL_CYCLES and QUAL_CYCLES+5 cycles.
- R5: The qualification latency is the same for every transition, into or out of any mode.
- R6: A change of candidate before the delay expires restarts the delay for the new candidate. An abandoned candidate never becomes the qualified mode.
- R7: `term_en` and `lvd_stat` are 1 only when the qualified mode is low-voltage differential and no override is active. In the other two modes they are 0.
- R8: While `disc_req` is high, `term_en` and `lvd_stat` go to 0 within 3 cycles. Qualification keeps running, and once the request is released termination returns within 3 cycles if the mode is still low-voltage differential.
- R9: While `hot_flag` is high, `term_en` and `lvd_stat` go to 0 within 3 cycles and stay 0. They may return only after the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_lo | input | 1 | Sense level below the low threshold (asynchronous) |
| sense_mid | input | 1 | Sense level inside the middle window (asynchronous) |
| sense_hi | input | 1 | Sense level above the high threshold (asynchronous) |
| disc_req | input | 1 | Disconnect request, high forces termination off (asynchronous) |
| hot_flag | input | 1 | Over-temperature flag, high forces termination off (asynchronous) |
| term_en | output | 1 | Termination enable |
| lvd_stat | output | 1 | Low-voltage differential status |
| mode_code | output | 2 | Qualified mode code |

## Verification
A corrupted candidate or timer shows at `mode_code` as a transition that comes early, late or to the wrong mode. Each transition's latency is therefore measured to the cycle and compared against the first one, so a timer that is off by one is exposed on the next mode change. An abandoned candidate that leaks through appears as an unexpected 2'b01 during the restart scenario. Override faults show as `term_en` still high three cycles after `disc_req` or `hot_flag` rises.

// File: rtl/busmode_pkg.sv
package busmode_pkg;
  typedef enum logic [1:0] {
    MODE_SE  = 2'b00,
    MODE_LVD = 2'b01,
    MODE_HVD = 2'b10
  } mode_t;
endpackage

// File: rtl/bm_sync.sv
module bm_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk) begin
      if (rst) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
      end else begin
        st1 <= d_in[i];
        st2 <= st1;
      end
    end
    assign d_out[i] = st2;
  end
endmodule

// File: rtl/bm_classify.sv
module bm_classify
  import busmode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  lo_s,
  input  logic  mid_s,
  input  logic  hi_s,
  output mode_t cand
);
  mode_t next_cand;

  // Low region wins: a single-ended driver pulls the sense line down
  // even when high-voltage drivers are also present.
  always_comb begin
    next_cand = cand;
    if (lo_s)       next_cand = MODE_SE;
    else if (hi_s)  next_cand = MODE_HVD;
    else if (mid_s) next_cand = MODE_LVD;
  end

  always_ff @(posedge clk) begin
    if (rst) cand <= MODE_SE;
    else     cand <= next_cand;
  end
endmodule

// File: rtl/bm_qual_timer.sv
module bm_qual_timer
  import busmode_pkg::*;
#(
  parameter int QUAL_CYCLES = 40,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_t            cand,
  output mode_t            qmode,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYCLES - 1);

  mode_t seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      qmode <= MODE_SE;
      seen  <= MODE_SE;
      cnt   <= '0;
    end else begin
      seen <= cand;
      if (cand == qmode) begin
        cnt <= '0;
      end else if (cand != seen) begin
        cnt <= CNT_W'(1);
      end else if (cnt == LAST) begin
        qmode <= cand;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/busmode_qual.sv
module busmode_qual
  import busmode_pkg::*;
#(
  parameter int CLK_KHZ  = 250000,
  parameter int DELAY_MS = 190
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sense_lo,
  input  logic       sense_mid,
  input  logic       sense_hi,
  input  logic       disc_req,
  input  logic       hot_flag,
  output logic       term_en,
  output logic       lvd_stat,
  output logic [1:0] mode_code
);
  localparam int QUAL_CYCLES = CLK_KHZ * DELAY_MS;
  localparam int CNT_W       = $clog2(QUAL_CYCLES + 1);

  logic [4:0]       raw_in, syn;
  logic             lo_s, mid_s, hi_s, disc_s, hot_s;
  mode_t            cand, qmode;
  logic [CNT_W-1:0] tmr_cnt;
  logic             enable_ok;

  assign raw_in = {hot_flag, disc_req, sense_hi, sense_mid, sense_lo};

  bm_sync #(.W(5)) u_sync (
    .clk(clk), .rst(rst), .d_in(raw_in), .d_out(syn)
  );

  assign {hot_s, disc_s, hi_s, mid_s, lo_s} = syn;

  bm_classify u_class (
    .clk(clk), .rst(rst), .lo_s(lo_s), .mid_s(mid_s), .hi_s(hi_s), .cand(cand)
  );

  bm_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .cand(cand), .qmode(qmode), .cnt(tmr_cnt)
  );

  assign enable_ok = (qmode == MODE_LVD) && !disc_s && !hot_s;
  assign term_en   = enable_ok;
  assign lvd_stat  = enable_ok;
  assign mode_code = qmode;
endmodule

// File: rtl/bm_checker.sv
module bm_checker
  import busmode_pkg::*;
#(
  parameter int QUAL_CYCLES = 40,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             disc_req,
  input logic             hot_flag,
  input logic             term_en,
  input logic             lvd_stat,
  input logic [1:0]       mode_code,
  input mode_t            cand,
  input logic [CNT_W-1:0] tmr_cnt
);
  assert_code_valid_R2: assert property (@(posedge clk) disable iff (rst)
    mode_code != 2'b11);

  assert_change_to_cand_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_code != $past(mode_code)) |-> (mode_code == 2'($past(cand))));

  assert_timer_bound_R4: assert property (@(posedge clk) disable iff (rst)
    tmr_cnt < CNT_W'(QUAL_CYCLES));

  assert_term_only_lvd_R7: assert property (@(posedge clk) disable iff (rst)
    (term_en || lvd_stat) |-> (mode_code == 2'b01));

  assert_disc_off_R8: assert property (@(posedge clk) disable iff (rst)
    (disc_req && $past(disc_req) && $past(disc_req, 2)) |-> !term_en);

  assert_hot_off_R9: assert property (@(posedge clk) disable iff (rst)
    (hot_flag && $past(hot_flag) && $past(hot_flag, 2)) |-> (!term_en && !lvd_stat));
endmodule

bind busmode_qual bm_checker #(.QUAL_CYCLES(QUAL_CYCLES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .disc_req(disc_req), .hot_flag(hot_flag),
  .term_en(term_en), .lvd_stat(lvd_stat), .mode_code(mode_code),
  .cand(cand), .tmr_cnt(tmr_cnt)
);

// File: tb/sim_busmode_qual.sv
`timescale 1ns/1ps
module sim_busmode_qual;
  localparam int KHZ  = 10;
  localparam int MS   = 4;
  localparam int QUAL = KHZ * MS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lo = 0, mid = 0, hi = 0, disc = 0, hot = 0;
  logic term_en, lvd_stat;
  logic [1:0] mode_code;

  int checks = 0, errors = 0, ref_lat = -1;
  bit done = 0;

  always #2 clk = ~clk;

  busmode_qual #(.CLK_KHZ(KHZ), .DELAY_MS(MS)) u0 (
    .clk(clk), .rst(rst), .sense_lo(lo), .sense_mid(mid), .sense_hi(hi),
    .disc_req(disc), .hot_flag(hot), .term_en(term_en), .lvd_stat(lvd_stat),
    .mode_code(mode_code)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_flags(logic l, logic m, logic h);
    lo = l; mid = m; hi = h;
  endtask

  // count negedges until mode_code moves away from its present value
  task automatic measure(output int lat);
    logic [1:0] start = mode_code;
    lat = 0;
    while (mode_code == start && lat < 4 * QUAL) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic qualify(logic l, logic m, logic h, logic [1:0] exp, string req);
    int lat;
    @(negedge clk);
    set_flags(l, m, h);
    measure(lat);
    chk({req, " mode"}, mode_code, exp);
    if (ref_lat < 0) ref_lat = lat;
    chk({req, " latency equal R5"}, lat, ref_lat);
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (4) @(negedge clk);
    chk("R1 mode in reset", mode_code, 0);
    chk("R1 term in reset", term_en, 0);
    chk("R1 lvd in reset", lvd_stat, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    chk("R1 mode after reset", mode_code, 0);
  endtask

  task automatic t_enter_lvd();
    int lat;
    @(negedge clk);
    set_flags(0, 1, 0);
    measure(lat);
    checks++;
    if (lat < QUAL || lat > QUAL + 5) begin
      errors++;
      $display("FAIL R4 latency actual=%0d expected=%0d..%0d", lat, QUAL, QUAL + 5);
    end
    ref_lat = lat;
    chk("R2 lvd code", mode_code, 1);
    chk("R7 term in lvd", term_en, 1);
    chk("R7 lvd_stat in lvd", lvd_stat, 1);
  endtask

  task automatic t_gap_hold();
    int lat = 0;
    @(negedge clk);
    set_flags(0, 0, 1);
    repeat (10) begin @(negedge clk); lat++; end
    set_flags(0, 0, 0);
    while (mode_code == 2'b01 && lat < 4 * QUAL) begin @(negedge clk); lat++; end
    chk("R3 empty sample holds candidate", mode_code, 2);
    chk("R5 latency into hvd", lat, ref_lat);
    chk("R7 term off in hvd", term_en, 0);
  endtask

  task automatic t_restart();
    int lat;
    @(negedge clk);
    set_flags(0, 1, 0);
    repeat (QUAL / 2) @(negedge clk);
    chk("R6 no early change", mode_code, 2);
    set_flags(1, 0, 0);
    measure(lat);
    chk("R6 abandoned lvd never qualifies", mode_code, 0);
    chk("R6 restarted latency", lat, ref_lat);
    chk("R7 term off in se", term_en, 0);
  endtask

  task automatic t_priority();
    qualify(0, 1, 0, 2'b01, "R4 se to lvd");
    qualify(1, 0, 1, 2'b00, "R3 low flag wins over high");
  endtask

  task automatic t_disc();
    qualify(0, 1, 0, 2'b01, "R4 re-enter lvd");
    @(negedge clk);
    disc = 1;
    repeat (3) @(negedge clk);
    chk("R8 term off", term_en, 0);
    chk("R8 lvd_stat off", lvd_stat, 0);
    chk("R8 mode kept", mode_code, 1);
    qualify(0, 0, 1, 2'b10, "R8 qualifies while disconnected");
    qualify(0, 1, 0, 2'b01, "R8 back to lvd while disconnected");
    chk("R8 term still off", term_en, 0);
    disc = 0;
    repeat (3) @(negedge clk);
    chk("R8 term restored", term_en, 1);
  endtask

  task automatic t_hot();
    @(negedge clk);
    hot = 1;
    repeat (3) @(negedge clk);
    chk("R9 term off hot", term_en, 0);
    repeat (50) @(negedge clk);
    chk("R9 stays off while hot", lvd_stat, 0);
    hot = 0;
    repeat (3) @(negedge clk);
    chk("R9 resumes after clear", term_en, 1);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    set_flags(0, 0, 1);
    repeat (20) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    chk("R1 reset mode", mode_code, 0);
    rst = 0;
    repeat (ref_lat - 3) @(negedge clk);
    chk("R1 timer cleared by reset", mode_code, 0);
    repeat (6) @(negedge clk);
    chk("R1 full delay after reset", mode_code, 2);
  endtask

  initial begin
    t_reset();
    t_enter_lvd();
    t_gap_hold();
    t_restart();
    t_priority();
    t_disc();
    t_hot();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule